// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps wall-clock time and calendar date in packed BCD bytes. A single-cycle enable at 32.768 kHz drives a binary prescaler, which emits one tick per second. That tick ripples through seconds, minutes, hours, day of week, date, month and year. Each field carries into the next at its rollover. The date field knows each month's length and handles February in leap years.

A register interface writes each field directly with a strobe, a field code and a data byte. A write is always accepted in the cycle it is presented, so there is no back-pressure and no handshake. A write to the seconds field restarts the prescaler. Bit 7 of that field halts counting. The hours byte selects either 24-hour encoding or 12-hour encoding with a PM flag. An optional 1 Hz square wave follows the prescaler's upper half, so it rises half a second after any seconds write.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset, the field bytes read as follows: seconds 0x00, minutes 0x00, hours 0x00 (24-hour mode), day 0x01, date 0x01, month 0x01, year 0x00. The square wave is low.
- R2: Seconds advance once every 2**DIV_BITS cycles with `tick_en` high (32768 by default). Cycles with `tick_en` low do not move the prescaler.
- R3: Seconds and minutes count 00–59 in BCD. Each wraps to 00 and carries into the next field.
- R4: When hours bit 6 is 0 (24-hour mode), bits 5:0 hold hours 00–23 in BCD. The step from 23 to 00 carries into the date fields.
- R5: When hours bit 6 is 1 (12-hour mode), bit 5 is PM and bits 4:0 hold 01–12 in BCD. 11→12 toggles PM. 12→01 keeps PM. The step from 11 PM to 12 AM carries into the date fields.
- R6: Day of week counts 1–7 on each date carry and wraps from 7 to 1.
- R7: Date wraps to 01 after the month's last day. The last day is 30 for April, June, September and November, and 31 for the other months except February. February ends on 29 when the BCD year is divisible by 4 and on 28 otherwise.
- R8: Month wraps from 12 to 01 and carries into year. Year wraps from 99 to 00.
- R9: While seconds bit 7 is 1, no field advances and the prescaler holds its count.
- R10: A seconds write clears the prescaler. The next seconds advance comes exactly 2**DIV_BITS enables later.
- R11: `sqw_o` is `sqw_en` AND the prescaler's upper half. It is low right after a seconds write and rises after 2**(DIV_BITS-1) enables.
- R12: A field write in the same cycle as an increment of that field stores the written value.
- R13: `wr_field` codes are 0 seconds, 1 minutes, 2 hours, 3 day, 4 date, 5 month and 6 year. Bits outside each field read as 0: minutes and hours keep bits 6:0, day keeps 2:0, date keeps 5:0 and month keeps 4:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | 32.768 kHz count enable |
| wr_stb | input | 1 | Field write strobe |
| wr_field | input | 3 | Field code of the write |
| wr_data | input | 8 | Write data byte |
| sqw_en | input | 1 | Square-wave output enable |
| sec_o | output | 8 | Halt bit and BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | Mode, PM/tens and BCD hours |
| dow_o | output | 8 | Day of week |
| date_o | output | 8 | BCD date |
| month_o | output | 8 | BCD month |
| year_o | output | 8 | BCD year |
| sqw_o | output | 1 | 1 Hz square wave |

## Verification
The hardest conditions to reach are the ones that need every field aligned: the midnight of December 31 in year 99, the leap-year end of February, and 11 PM rolling into 12 AM. The bench writes all seven fields to the value just before the edge, then gives the prescaler exactly one second of enables, with DIV_BITS shortened to 3. The collision of a field write with a carry into that field is set up by counting enables from a seconds write. The write is timed to land in the cycle the carry arrives. A seeded random phase then mixes gaps in the enables, writes of valid values and halts, all checked against a cycle model.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [2:0] {
    FLD_SEC  = 3'd0,
    FLD_MIN  = 3'd1,
    FLD_HOUR = 3'd2,
    FLD_DOW  = 3'd3,
    FLD_DATE = 3'd4,
    FLD_MON  = 3'd5,
    FLD_YEAR = 3'd6
  } fld_e;

  // one BCD step on a two-digit byte (no range check)
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // BCD year divisible by 4: tens even -> ones 0/4/8, tens odd -> ones 2/6
  function automatic logic leap_year(input logic [7:0] yr);
    if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction

  function automatic logic [5:0] month_last(input logic [4:0] mon, input logic [7:0] yr);
    case (mon)
      5'h02:                      return leap_year(yr) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_BITS = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic halt,
  input  logic restart,
  output logic sec_tick,
  output logic upper_half
);
  localparam logic [DIV_BITS-1:0] CNT_LAST = {DIV_BITS{1'b1}};
  localparam logic [DIV_BITS-1:0] CNT_ONE  = {{(DIV_BITS-1){1'b0}}, 1'b1};

  logic [DIV_BITS-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (restart)          cnt <= '0;
    else if (tick_en && !halt) cnt <= cnt + CNT_ONE;
  end

  assign sec_tick   = tick_en & ~halt & ~restart & (cnt == CNT_LAST);
  assign upper_half = cnt[DIV_BITS-1];

  a_r10_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));
  a_r9_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !restart) |=> $stable(cnt));
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !restart) |=> $stable(cnt));

endmodule

// File: rtl/rtc_time_fields.sv
module rtc_time_fields
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       wr_stb,
  input  logic [2:0] wr_field,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_q,
  output logic [7:0] min_q,
  output logic [7:0] hr_q,
  output logic       day_carry
);
  logic wr_sec, wr_min, wr_hr;
  logic min_carry, hr_carry;
  logic [7:0] hr_next;

  assign wr_sec = wr_stb && (wr_field == FLD_SEC);
  assign wr_min = wr_stb && (wr_field == FLD_MIN);
  assign wr_hr  = wr_stb && (wr_field == FLD_HOUR);

  assign min_carry = sec_tick & (sec_q[6:0] == 7'h59);
  assign hr_carry  = min_carry & (min_q == 8'h59);
  assign day_carry = hr_carry & (hr_q[6] ? (hr_q[5] && hr_q[4:0] == 5'h11)
                                         : (hr_q[5:0] == 6'h23));

  always_comb begin
    if (hr_q[6]) begin
      if (hr_q[4:0] == 5'h11)      hr_next = {2'b01, ~hr_q[5], 5'h12};
      else if (hr_q[4:0] == 5'h12) hr_next = {2'b01, hr_q[5], 5'h01};
      else hr_next = {2'b01, hr_q[5], 5'(bcd_inc({3'b000, hr_q[4:0]}))};
    end else if (hr_q[5:0] == 6'h23) begin
      hr_next = 8'h00;
    end else begin
      hr_next = {2'b00, 6'(bcd_inc({2'b00, hr_q[5:0]}))};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q <= 8'h00;
      min_q <= 8'h00;
      hr_q  <= 8'h00;
    end else begin
      if (wr_sec)        sec_q <= wr_data;
      else if (sec_tick) sec_q <= (sec_q[6:0] == 7'h59) ? {sec_q[7], 7'h00}
                                  : {sec_q[7], 7'(bcd_inc({1'b0, sec_q[6:0]}))};
      if (wr_min)         min_q <= {1'b0, wr_data[6:0]};
      else if (min_carry) min_q <= (min_q == 8'h59) ? 8'h00 : bcd_inc(min_q);
      if (wr_hr)         hr_q <= {1'b0, wr_data[6:0]};
      else if (hr_carry) hr_q <= hr_next;
    end
  end

  a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && sec_q[6:0] == 7'h59 && !wr_sec) |=> (sec_q[6:0] == 7'h00));
  a_r5_pm_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (hr_carry && hr_q[6] && hr_q[4:0] == 5'h11 && !wr_hr)
      |=> (hr_q[4:0] == 5'h12 && hr_q[5] != $past(hr_q[5])));
  a_r12_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_min |=> (min_q[6:0] == $past(wr_data[6:0])));

endmodule

// File: rtl/rtc_date_fields.sv
module rtc_date_fields
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       day_carry,
  input  logic       wr_stb,
  input  logic [2:0] wr_field,
  input  logic [7:0] wr_data,
  output logic [7:0] dow_q,
  output logic [7:0] date_q,
  output logic [7:0] mon_q,
  output logic [7:0] yr_q
);
  logic wr_dow, wr_date, wr_mon, wr_yr;
  logic mon_carry, yr_carry;

  assign wr_dow  = wr_stb && (wr_field == FLD_DOW);
  assign wr_date = wr_stb && (wr_field == FLD_DATE);
  assign wr_mon  = wr_stb && (wr_field == FLD_MON);
  assign wr_yr   = wr_stb && (wr_field == FLD_YEAR);

  assign mon_carry = day_carry & (date_q == {2'b00, month_last(mon_q[4:0], yr_q)});
  assign yr_carry  = mon_carry & (mon_q == 8'h12);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dow_q  <= 8'h01;
      date_q <= 8'h01;
      mon_q  <= 8'h01;
      yr_q   <= 8'h00;
    end else begin
      if (wr_dow)         dow_q <= {5'b0, wr_data[2:0]};
      else if (day_carry) dow_q <= (dow_q == 8'h07) ? 8'h01 : dow_q + 8'h01;
      if (wr_date)        date_q <= {2'b0, wr_data[5:0]};
      else if (day_carry) date_q <= mon_carry ? 8'h01 : bcd_inc(date_q);
      if (wr_mon)         mon_q <= {3'b0, wr_data[4:0]};
      else if (mon_carry) mon_q <= yr_carry ? 8'h01 : bcd_inc(mon_q);
      if (wr_yr)          yr_q <= wr_data;
      else if (yr_carry)  yr_q <= (yr_q == 8'h99) ? 8'h00 : bcd_inc(yr_q);
    end
  end

  a_r6_dow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && dow_q == 8'h07 && !wr_dow) |=> (dow_q == 8'h01));
  a_r7_leap_day: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && mon_q == 8'h02 && date_q == 8'h28 && leap_year(yr_q) && !wr_date)
      |=> (date_q == 8'h29));
  a_r8_year_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (yr_carry && yr_q == 8'h99 && !wr_yr) |=> (yr_q == 8'h00));

endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_pkg::*;
#(
  parameter int DIV_BITS = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       wr_stb,
  input  logic [2:0] wr_field,
  input  logic [7:0] wr_data,
  input  logic       sqw_en,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic       sqw_o
);
  logic sec_wr, sec_tick, upper_half, day_carry;

  assign sec_wr = wr_stb && (wr_field == FLD_SEC);

  rtc_prescaler #(.DIV_BITS(DIV_BITS)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .halt(sec_o[7]),
    .restart(sec_wr), .sec_tick(sec_tick), .upper_half(upper_half)
  );

  rtc_time_fields u_time (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_stb(wr_stb),
    .wr_field(wr_field), .wr_data(wr_data), .sec_q(sec_o), .min_q(min_o),
    .hr_q(hour_o), .day_carry(day_carry)
  );

  rtc_date_fields u_date (
    .clk(clk), .rst_n(rst_n), .day_carry(day_carry), .wr_stb(wr_stb),
    .wr_field(wr_field), .wr_data(wr_data), .dow_q(dow_o), .date_q(date_o),
    .mon_q(month_o), .yr_q(year_o)
  );

  assign sqw_o = sqw_en & upper_half;

  a_r11_sqw_low_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wr |=> !sqw_o);

endmodule

// File: tb/test_rtc_bcd_core.sv
module test_rtc_bcd_core;
  localparam int DIVB = 3;
  localparam int DIVN = 1 << DIVB;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, tick_en, wr_stb, sqw_en;
  logic [2:0] wr_field;
  logic [7:0] wr_data;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
  logic sqw_o;

  rtc_bcd_core #(.DIV_BITS(DIVB)) i_rtc_bcd_core (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_stb(wr_stb),
    .wr_field(wr_field), .wr_data(wr_data), .sqw_en(sqw_en),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o), .sqw_o(sqw_o)
  );

  int n_run = 0, n_fail = 0;
  int m_div, m_halt, m_sec, m_min, m_h, m_pm, m_m12, m_dow, m_date, m_mon, m_yr;

  function automatic logic [7:0] bin2bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction
  function automatic int bcd2bin(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic int mdays(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] e_sec();
    return bin2bcd(m_sec) | (m_halt != 0 ? 8'h80 : 8'h00);
  endfunction
  function automatic logic [7:0] e_hour();
    if (m_m12 != 0) return 8'h40 | (m_pm != 0 ? 8'h20 : 8'h00) | bin2bcd(m_h);
    return bin2bcd(m_h);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R3 seconds", sec_o, e_sec());
    chk("R3 minutes", min_o, bin2bcd(m_min));
    chk(m_m12 != 0 ? "R5 hours" : "R4 hours", hour_o, e_hour());
    chk("R6 day", dow_o, 8'(m_dow));
    chk("R7 date", date_o, bin2bcd(m_date));
    chk("R8 month", month_o, bin2bcd(m_mon));
    chk("R8 year", year_o, bin2bcd(m_yr));
    chk("R11 square wave", {7'b0, sqw_o}, {7'b0, (sqw_en && m_div >= DIVN / 2)});
  endtask

  // drive at a negedge, model the posedge, compare at the next negedge
  task automatic step(input bit t, input bit w, input int f, input logic [7:0] d);
    bit sw, ts, cm, ch, cd, cmo, cy;
    tick_en = t; wr_stb = w; wr_field = 3'(f); wr_data = d;
    sw  = w && f == 0;
    ts  = t && m_halt == 0 && m_div == DIVN - 1 && !sw;
    cm  = ts && m_sec == 59;
    ch  = cm && m_min == 59;
    cd  = ch && (m_m12 != 0 ? (m_h == 11 && m_pm != 0) : m_h == 23);
    cmo = cd && m_date == mdays(m_mon, m_yr);
    cy  = cmo && m_mon == 12;
    if (sw) m_div = 0;
    else if (t && m_halt == 0) m_div = (m_div + 1) % DIVN;
    if (sw) begin m_halt = int'(d[7]); m_sec = bcd2bin({1'b0, d[6:0]}); end
    else if (ts) m_sec = (m_sec + 1) % 60;
    if (w && f == 1) m_min = bcd2bin({1'b0, d[6:0]});
    else if (cm) m_min = (m_min + 1) % 60;
    if (w && f == 2) begin
      m_m12 = int'(d[6]);
      if (d[6]) begin m_pm = int'(d[5]); m_h = bcd2bin({3'b0, d[4:0]}); end
      else begin m_pm = 0; m_h = bcd2bin({2'b0, d[5:0]}); end
    end else if (ch) begin
      if (m_m12 != 0) begin
        if (m_h == 11) begin m_h = 12; m_pm = 1 - m_pm; end
        else if (m_h == 12) m_h = 1;
        else m_h = m_h + 1;
      end else m_h = (m_h + 1) % 24;
    end
    if (w && f == 3) m_dow = int'(d[2:0]);
    else if (cd) m_dow = (m_dow == 7) ? 1 : m_dow + 1;
    if (w && f == 4) m_date = bcd2bin({2'b0, d[5:0]});
    else if (cd) m_date = cmo ? 1 : m_date + 1;
    if (w && f == 5) m_mon = bcd2bin({3'b0, d[4:0]});
    else if (cmo) m_mon = cy ? 1 : m_mon + 1;
    if (w && f == 6) m_yr = bcd2bin(d);
    else if (cy) m_yr = (m_yr + 1) % 100;
    @(negedge clk);
    compare_all();
    tick_en = 1'b0; wr_stb = 1'b0;
  endtask

  task automatic wr(input int f, input logic [7:0] d);
    step(1'b0, 1'b1, f, d);
  endtask
  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 0, 8'h00);
  endtask
  task automatic set_all(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                         input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                         input logic [7:0] y);
    wr(1, mi); wr(2, h); wr(3, dw); wr(4, dt); wr(5, mo); wr(6, y); wr(0, s);
  endtask

  function automatic logic [7:0] rand_val(input int f);
    logic [7:0] v;
    case (f)
      0: begin
        v = bin2bcd(int'($urandom_range(0, 59)));
        if ($urandom_range(0, 9) == 0) v[7] = 1'b1;
      end
      1: v = bin2bcd(int'($urandom_range(0, 59)));
      2: if ($urandom_range(0, 1) == 1)
           v = 8'h40 | ($urandom_range(0, 1) == 1 ? 8'h20 : 8'h00) | bin2bcd(int'($urandom_range(1, 12)));
         else v = bin2bcd(int'($urandom_range(0, 23)));
      3: v = 8'($urandom_range(1, 7));
      4: v = bin2bcd(int'($urandom_range(1, 28)));
      5: v = bin2bcd(int'($urandom_range(1, 12)));
      default: v = bin2bcd(int'($urandom_range(0, 99)));
    endcase
    return v;
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 1'b0; tick_en = 1'b0; wr_stb = 1'b0; wr_field = 3'd0; wr_data = 8'h00; sqw_en = 1'b1;
    m_div = 0; m_halt = 0; m_sec = 0; m_min = 0; m_h = 0; m_pm = 0; m_m12 = 0;
    m_dow = 1; m_date = 1; m_mon = 1; m_yr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 seconds", sec_o, 8'h00);   chk("R1 minutes", min_o, 8'h00);
    chk("R1 hours", hour_o, 8'h00);    chk("R1 day", dow_o, 8'h01);
    chk("R1 date", date_o, 8'h01);     chk("R1 month", month_o, 8'h01);
    chk("R1 year", year_o, 8'h00);     chk("R1 square wave", {7'b0, sqw_o}, 8'h00);

    // R13 field masks
    wr(3, 8'hF5); chk("R13 day mask", dow_o, 8'h05);
    wr(4, 8'hC9); chk("R13 date mask", date_o, 8'h09);
    wr(1, 8'hA3); chk("R13 minute mask", min_o, 8'h23);

    // R2 / R10 / R11 prescaler phase
    wr(0, 8'h10);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 0, 8'h00);
    chk("R2 no enables no advance", sec_o, 8'h10);
    run(DIVN / 2 - 1); chk("R11 still low", {7'b0, sqw_o}, 8'h00);
    run(1);            chk("R11 rises half way", {7'b0, sqw_o}, 8'h01);
    run(DIVN / 2 - 1); chk("R10 not yet advanced", sec_o, 8'h10);
    run(1);            chk("R10 advance after full count", sec_o, 8'h11);

    // R9 halt
    wr(0, 8'h85); run(3 * DIVN); chk("R9 halted seconds", sec_o, 8'h85);
    wr(0, 8'h05); run(DIVN);     chk("R9 resumed seconds", sec_o, 8'h06);

    // R4 R6 R8 new year in 24-hour mode
    set_all(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99); run(DIVN);
    chk("R4 hour wrap", hour_o, 8'h00); chk("R6 day wrap", dow_o, 8'h01);
    chk("R8 month wrap", month_o, 8'h01); chk("R8 year wrap", year_o, 8'h00);

    // R5 12-hour transitions
    set_all(8'h59, 8'h59, 8'h71, 8'h03, 8'h15, 8'h06, 8'h10); run(DIVN);
    chk("R5 11PM to 12AM", hour_o, 8'h52); chk("R5 midnight date", date_o, 8'h16);
    set_all(8'h59, 8'h59, 8'h51, 8'h03, 8'h15, 8'h06, 8'h10); run(DIVN);
    chk("R5 11AM to 12PM", hour_o, 8'h72); chk("R5 noon no date", date_o, 8'h15);
    set_all(8'h59, 8'h59, 8'h72, 8'h03, 8'h15, 8'h06, 8'h10); run(DIVN);
    chk("R5 12PM to 1PM", hour_o, 8'h61);

    // R7 month lengths
    set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24); run(DIVN);
    chk("R7 leap Feb 29", date_o, 8'h29);
    set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h24); run(DIVN);
    chk("R7 leap to Mar 1", month_o, 8'h03);
    set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23); run(DIVN);
    chk("R7 common Feb end", date_o, 8'h01);
    set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h23); run(DIVN);
    chk("R7 April end", month_o, 8'h05);

    // R12 write collides with minute carry
    wr(0, 8'h59); run(DIVN - 1);
    step(1'b1, 1'b1, 1, 8'h42);
    chk("R12 write wins", min_o, 8'h42); chk("R12 seconds wrapped", sec_o, 8'h00);

    // seeded random mix
    for (int i = 0; i < 3000; i++) begin
      int f;
      f = int'($urandom_range(0, 6));
      if ($urandom_range(0, 63) == 0) sqw_en = ~sqw_en;
      if ($urandom_range(0, 19) == 0) step($urandom_range(0, 3) != 0, 1'b1, f, rand_val(f));
      else step($urandom_range(0, 3) != 0, 1'b0, 0, 8'h00);
    end

    summary();
    $finish;
  end
endmodule